// File: doc/BRIEF.md
# Edge-Latched Static Memory Cycle Sequencer

This block sits between a synchronous host port and an asynchronous byte-wide static memory. The memory captures its address when the chip enable falls. The host offers one request at a time with a valid/ready handshake: a direction bit, an address and, for stores, a byte of write data. The sequencer turns each request into a chip-enable, write-enable and output-enable sequence. Loads come back as a one-cycle response carrying the byte that was read.

Every analogue limit is a nanosecond parameter. At elaboration each one is converted to a whole number of system clock cycles by rounding up. These limits are the address hold after the enable falls, the minimum enable low and high widths, the fall-to-fall cycle time, the access times from chip enable and from output enable, the write pulse width, and the write-data setup and hold around the rising write enable. The address register is loaded when the request is accepted. It is presented for one full cycle before the enable falls and stays unchanged until the enable rises. For stores, the data bus is driven with a separate enable. Output enable stays high, so the memory and the controller never drive the bus at the same time.

The host may keep its valid asserted, and requests then run back to back. Acceptance waits until a recovery interval has elapsed. That interval is sized at elaboration to meet both the enable-high minimum and the total cycle minimum.

Top module: `sramc_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, chip enable, write enable and output enable are high (all are active low), the data drive enable is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `req_ready` is 1 only while the sequencer is idle, and never while chip enable is low. A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge. Its address appears on `mem_addr` one full cycle before chip enable falls and holds unchanged while chip enable stays low. Each accepted request produces exactly one chip-enable low phase, in acceptance order.
- R3: Every chip-enable low phase lasts at least ceil(T_CE_LOW_NS/CLK_NS) cycles.
- R4: Between two low phases, chip enable is high for at least ceil(T_CE_HIGH_NS/CLK_NS) cycles. Successive falling edges are at least ceil(T_CYCLE_NS/CLK_NS) cycles apart.
- R5: During a load (`req_write`=0), write enable stays high. Output enable is low for exactly the cycles in which chip enable is low. The data drive enable stays 0.
- R6: A load keeps chip enable low for max(ceil(T_CE_ACCESS_NS/CLK_NS), ceil(T_OE_ACCESS_NS/CLK_NS), ceil(T_CE_LOW_NS/CLK_NS)-1)+1 cycles. `mem_dq_in` is captured at the edge that raises chip enable. In the first cycle with chip enable high, `rsp_valid` is 1 for exactly one cycle and `rsp_rdata` holds the stored byte.
- R7: During a store (`req_write`=1), output enable stays high. Write enable falls with chip enable and stays low for exactly max(ceil(T_WE_LOW_NS/CLK_NS), ceil(T_WD_SETUP_NS/CLK_NS)) cycles. Throughout that pulse the drive enable is 1 and `mem_dq_out` equals the request's write data.
- R8: After write enable rises, chip enable stays low for at least max(ceil(T_WD_HOLD_NS/CLK_NS),1) cycles, with the drive enable still 1 and the write data unchanged.
- R9: A store produces no `rsp_valid` pulse, and `rsp_valid` is never 1 outside the first high cycle after a load.
- R10: The drive enable is never 1 while output enable is low. Write enable is never low while chip enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | One-cycle pulse, load data available |
| rsp_rdata | output | DATA_W | Byte returned by a load |
| mem_addr | output | ADDR_W | Address to memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data returned by memory |

## Verification
With the default 4 ns clock, a request taken at edge k lowers chip enable at edge k+1. A load then keeps chip enable low for 31 cycles and raises `rsp_valid` in the same cycle chip enable goes high, 32 cycles after acceptance. A store keeps write enable low for 30 cycles, then holds the data for 3 more before chip enable rises. The behavioural memory in the bench returns a poisoned byte until enough nanoseconds have passed since chip enable and output enable fell, so a capture one cycle early is caught. All pins are sampled on the falling clock edge, and each width or gap is counted from the sampled edges. Every width is compared with bounds the bench derives on its own from the nanosecond parameters.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACCESS,
      ST_SAMPLE,
      ST_COMMIT,
      ST_RECOVER
   } seq_st_e;

   // Round a nanosecond limit up to whole clock cycles.
   function automatic int ns2cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // a running interval only ever shrinks by one per cycle
   assert_timer_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load) && ($past(cnt_q) != '0)) |-> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/sramc_fsm.sv
module sramc_fsm
   import sramc_pkg::*;
#(
   parameter int CW       = 6,
   parameter int RD_ACC   = 30,
   parameter int RD_REC   = 11,
   parameter int WR_PULSE = 30,
   parameter int WR_TAIL  = 3,
   parameter int WR_REC   = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   output logic          req_ready,
   output logic          accept,
   output logic          cap_rd,
   output logic          tmr_load,
   output logic [CW-1:0] tmr_val,
   input  logic          tmr_expired,
   output logic          ce_n,
   output logic          we_n,
   output logic          oe_n,
   output logic          dq_oe
);

   seq_st_e st_q, st_d;
   logic    op_wr_q;

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign cap_rd    = (st_q == ST_SAMPLE);

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (st_q)
         ST_IDLE:
            if (req_valid) st_d = ST_ADDR;
         ST_ADDR: begin
            st_d     = ST_ACCESS;
            tmr_load = 1'b1;
            tmr_val  = op_wr_q ? CW'(WR_PULSE - 1) : CW'(RD_ACC - 1);
         end
         ST_ACCESS:
            if (tmr_expired) begin
               if (op_wr_q) begin
                  st_d     = ST_COMMIT;
                  tmr_load = 1'b1;
                  tmr_val  = CW'(WR_TAIL - 1);
               end else begin
                  st_d = ST_SAMPLE;
               end
            end
         ST_SAMPLE: begin
            st_d     = ST_RECOVER;
            tmr_load = 1'b1;
            tmr_val  = CW'(RD_REC - 1);
         end
         ST_COMMIT:
            if (tmr_expired) begin
               st_d     = ST_RECOVER;
               tmr_load = 1'b1;
               tmr_val  = CW'(WR_REC - 1);
            end
         ST_RECOVER:
            if (tmr_expired) st_d = ST_IDLE;
         default:
            st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         op_wr_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (accept) op_wr_q <= req_write;
      end
   end

   // Pins are registered from the next state so they switch with the state.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_n  <= 1'b1;
         we_n  <= 1'b1;
         oe_n  <= 1'b1;
         dq_oe <= 1'b0;
      end else begin
         ce_n  <= !(st_d inside {ST_ACCESS, ST_SAMPLE, ST_COMMIT});
         we_n  <= !(op_wr_q && (st_d == ST_ACCESS));
         oe_n  <= !(!op_wr_q && (st_d inside {ST_ACCESS, ST_SAMPLE}));
         dq_oe <= op_wr_q && (st_d inside {ST_ACCESS, ST_COMMIT});
      end
   end

   assert_idle_ce_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> ce_n);

   assert_recover_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RECOVER) |-> (ce_n && we_n && oe_n && !dq_oe));

endmodule

// File: rtl/sramc_data.sv
module sramc_data #(
   parameter int AW         = 11,
   parameter int DW         = 8,
   parameter bit DATA_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          cap_rd,
   input  logic [DW-1:0] mem_dq_in,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_dq_out,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata
);

   generate
      if (DATA_RESET) begin : g_rst_data
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem_addr   <= '0;
               mem_dq_out <= '0;
               rsp_rdata  <= '0;
            end else begin
               if (accept) begin
                  mem_addr   <= req_addr;
                  mem_dq_out <= req_wdata;
               end
               if (cap_rd) rsp_rdata <= mem_dq_in;
            end
         end
      end else begin : g_free_data
         always_ff @(posedge clk) begin
            if (accept) begin
               mem_addr   <= req_addr;
               mem_dq_out <= req_wdata;
            end
            if (cap_rd) rsp_rdata <= mem_dq_in;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsp_valid <= 1'b0;
      else        rsp_valid <= cap_rd;
   end

   assert_rsp_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
   import sramc_pkg::*;
#(
   parameter int ADDR_W         = 11,
   parameter int DATA_W         = 8,
   parameter int CLK_NS         = 4,
   parameter int T_ADDR_HOLD_NS = 30,
   parameter int T_CE_LOW_NS    = 120,
   parameter int T_CE_HIGH_NS   = 50,
   parameter int T_CYCLE_NS     = 170,
   parameter int T_CE_ACCESS_NS = 120,
   parameter int T_OE_ACCESS_NS = 50,
   parameter int T_WE_LOW_NS    = 120,
   parameter int T_WD_SETUP_NS  = 50,
   parameter int T_WD_HOLD_NS   = 10,
   parameter bit DATA_RESET     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int C_AH  = ns2cyc(T_ADDR_HOLD_NS, CLK_NS);
   localparam int C_EL  = ns2cyc(T_CE_LOW_NS, CLK_NS);
   localparam int C_EH  = ns2cyc(T_CE_HIGH_NS, CLK_NS);
   localparam int C_CYC = ns2cyc(T_CYCLE_NS, CLK_NS);
   localparam int C_ACC = ns2cyc(T_CE_ACCESS_NS, CLK_NS);
   localparam int C_OE  = ns2cyc(T_OE_ACCESS_NS, CLK_NS);
   localparam int C_WE  = ns2cyc(T_WE_LOW_NS, CLK_NS);
   localparam int C_DS  = ns2cyc(T_WD_SETUP_NS, CLK_NS);
   localparam int C_DH  = ns2cyc(T_WD_HOLD_NS, CLK_NS);

   // load: access then one sample cycle
   localparam int RD_ACC   = imax(imax(imax(C_ACC, C_OE), C_EL - 1), 1);
   localparam int RD_LOW   = RD_ACC + 1;
   // store: write pulse then data hold tail
   localparam int WR_PULSE = imax(imax(C_WE, C_DS), 1);
   localparam int WR_TAIL  = imax(imax(C_DH, 1), C_EL - WR_PULSE);
   localparam int WR_LOW   = WR_PULSE + WR_TAIL;
   // idle and address cycles add two more high cycles after recovery
   localparam int RD_REC   = imax(imax(C_EH - 2, C_CYC - RD_LOW - 2), 1);
   localparam int WR_REC   = imax(imax(C_EH - 2, C_CYC - WR_LOW - 2), 1);
   localparam int MAXLD    = imax(imax(RD_ACC, RD_REC), imax(imax(WR_PULSE, WR_TAIL), WR_REC));
   localparam int CW       = $clog2(MAXLD + 1);
   localparam int LCW      = $clog2(imax(RD_LOW, WR_LOW) + 2);

   initial begin : elab_checks
      assert (CLK_NS > 0) else $error("CLK_NS must be positive");
      assert (ADDR_W > 0 && DATA_W > 0) else $error("bus widths must be positive");
      assert (C_AH <= RD_LOW && C_AH <= WR_LOW)
         else $error("address hold longer than enable low phase");
   end

   logic          accept, cap_rd, tmr_load, tmr_expired;
   logic [CW-1:0] tmr_val;

   sramc_fsm #(
      .CW(CW), .RD_ACC(RD_ACC), .RD_REC(RD_REC),
      .WR_PULSE(WR_PULSE), .WR_TAIL(WR_TAIL), .WR_REC(WR_REC)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_ready(req_ready),
      .accept(accept), .cap_rd(cap_rd),
      .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_expired(tmr_expired),
      .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .dq_oe(mem_dq_oe)
   );

   sramc_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
   );

   sramc_data #(.AW(ADDR_W), .DW(DATA_W), .DATA_RESET(DATA_RESET)) u_data (
      .clk(clk), .rst_n(rst_n),
      .accept(accept), .req_addr(req_addr), .req_wdata(req_wdata),
      .cap_rd(cap_rd), .mem_dq_in(mem_dq_in),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
   );

   // ---- pin-level checks ----
   logic [LCW-1:0] ce_lo_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ce_lo_cnt <= '0;
      else if (!mem_ce_n) ce_lo_cnt <= ce_lo_cnt + 1'b1;
      else               ce_lo_cnt <= '0;
   end

   assert_ce_low_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_ce_n) |-> (ce_lo_cnt >= LCW'(C_EL)));

   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

   assert_ready_ce_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> mem_ce_n);

   assert_we_oe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n);

   assert_rsp_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (mem_ce_n && !$past(mem_ce_n)));

   assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   assert_we_inside_ce_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !mem_ce_n);

endmodule

// File: tb/sramc_ctrl_test.sv
`timescale 1ns/1ps
module sramc_ctrl_test;

   localparam int AW = 11;
   localparam int DW = 8;
   localparam int CLK = 4;
   localparam int NS_AH = 30, NS_EL = 120, NS_EH = 50, NS_CYC = 170;
   localparam int NS_ACC = 120, NS_OE = 50, NS_WE = 120, NS_DS = 50, NS_DH = 10;

   function automatic int up(input int ns);
      return (ns + CLK - 1) / CLK;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int B_EL       = up(NS_EL);
   localparam int B_EH       = up(NS_EH);
   localparam int B_CYC      = up(NS_CYC);
   localparam int B_DH       = mx(up(NS_DH), 1);
   localparam int B_RD_LOW   = mx(mx(up(NS_ACC), up(NS_OE)), B_EL - 1) + 1;
   localparam int B_WR_PULSE = mx(up(NS_WE), up(NS_DS));

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
   logic [AW-1:0] mem_addr;

   always #(CLK / 2.0) clk = ~clk;

   sramc_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK),
      .T_ADDR_HOLD_NS(NS_AH), .T_CE_LOW_NS(NS_EL), .T_CE_HIGH_NS(NS_EH),
      .T_CYCLE_NS(NS_CYC), .T_CE_ACCESS_NS(NS_ACC), .T_OE_ACCESS_NS(NS_OE),
      .T_WE_LOW_NS(NS_WE), .T_WD_SETUP_NS(NS_DS), .T_WD_HOLD_NS(NS_DH)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   int checks = 0, errors = 0;
   bit done = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ---- behavioural memory ----
   logic [DW-1:0] dev_mem [0:(1<<AW)-1];
   logic [DW-1:0] ref_mem [0:(1<<AW)-1];
   int ce_age = 0, oe_age = 0;

   initial begin
      for (int a = 0; a < (1 << AW); a++) begin
         dev_mem[a] = DW'(a * 7 + 1);
         ref_mem[a] = DW'(a * 7 + 1);
      end
   end

   always @(posedge clk) begin
      ce_age <= mem_ce_n ? 0 : ce_age + 1;
      oe_age <= mem_oe_n ? 0 : oe_age + 1;
      if (!mem_ce_n && !mem_we_n && mem_dq_oe) dev_mem[mem_addr] <= mem_dq_out;
   end

   assign mem_dq_in = (!mem_ce_n && !mem_oe_n && ce_age * CLK >= NS_ACC &&
                       oe_age * CLK >= NS_OE) ? dev_mem[mem_addr] : 8'hEE;

   // ---- scoreboard ----
   typedef struct packed {
      logic          wr;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
   } txn_t;
   txn_t txq[$];

   task automatic send(input bit wr, input int a, input int d);
      txn_t t;
      t.wr   = wr;
      t.addr = AW'(a);
      t.data = wr ? DW'(d) : ref_mem[a];
      if (wr) ref_mem[a] = DW'(d);
      txq.push_back(t);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = AW'(a);
      req_wdata = DW'(d);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
   endtask

   // ---- monitor (negedge) ----
   bit   prev_ce = 1'b1, seen_rise = 1'b0, active = 1'b0;
   int   lo_cnt = 0, hi_cnt = 0, gap = 0, we_cnt = 0, tail = 0, txns = 0;
   bit   f_addr, f_ctrl, f_data;
   txn_t cur;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         gap++;
         if (req_ready && !mem_ce_n) check(0, "R2", "ready while ce low", 1, 0);
         if (!mem_ce_n && prev_ce) begin
            if (seen_rise) begin
               check(hi_cnt >= B_EH, "R4", "ce high width", hi_cnt, B_EH);
               check(gap >= B_CYC, "R4", "fall-to-fall cycles", gap, B_CYC);
            end
            gap = 0;
            if (txq.size() == 0) begin
               check(0, "R2", "ce fall with no request", 0, 1);
               active = 0;
            end else begin
               cur = txq.pop_front();
               active = 1;
               txns++;
            end
            lo_cnt = 0; we_cnt = 0; tail = 0;
            f_addr = 0; f_ctrl = 0; f_data = 0;
         end
         if (!mem_ce_n && active) begin
            lo_cnt++;
            if (mem_addr != cur.addr) f_addr = 1;
            if (cur.wr) begin
               if (!mem_oe_n) f_ctrl = 1;
               if (!mem_we_n) begin
                  if (tail != 0) f_ctrl = 1;
                  we_cnt++;
               end else tail++;
               if (!mem_dq_oe || mem_dq_out != cur.data) f_data = 1;
            end else begin
               if (!mem_we_n || mem_oe_n || mem_dq_oe) f_ctrl = 1;
            end
         end
         if (mem_ce_n && !prev_ce && active) begin
            check(lo_cnt >= B_EL, "R3", "ce low width", lo_cnt, B_EL);
            check(!f_addr, "R2", "address held while ce low", f_addr, 0);
            if (cur.wr) begin
               check(!f_ctrl, "R7", "store control pins", f_ctrl, 0);
               check(we_cnt == B_WR_PULSE, "R7", "we low width", we_cnt, B_WR_PULSE);
               check(!f_data, "R7", "store data driven", f_data, 0);
               check(tail >= B_DH, "R8", "hold after we rise", tail, B_DH);
               check(!rsp_valid, "R9", "no response for store", rsp_valid, 0);
            end else begin
               check(!f_ctrl, "R5", "load control pins", f_ctrl, 0);
               check(lo_cnt == B_RD_LOW, "R6", "load ce low width", lo_cnt, B_RD_LOW);
               check(rsp_valid, "R6", "response with ce rise", rsp_valid, 1);
               check(rsp_rdata == cur.data, "R6", "load data", rsp_rdata, cur.data);
            end
            active = 0;
            seen_rise = 1;
            hi_cnt = 0;
         end else if (rsp_valid) begin
            check(0, "R9", "stray rsp_valid", 1, 0);
         end
         if (mem_ce_n) hi_cnt++;
         if (mem_dq_oe && !mem_oe_n) check(0, "R10", "bus contention", 1, 0);
         if (!mem_we_n && mem_ce_n) check(0, "R10", "we low with ce high", 1, 0);
         prev_ce = mem_ce_n;
      end
   end

   task automatic summary;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
      done = 1;
      summary();
      $finish;
   end

   initial begin : stimulus
      repeat (3) @(negedge clk);
      check(mem_ce_n && mem_we_n && mem_oe_n, "R1", "pins in reset",
            {mem_ce_n, mem_we_n, mem_oe_n}, 7);
      check(!mem_dq_oe && !rsp_valid, "R1", "drive and rsp in reset",
            {mem_dq_oe, rsp_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready, "R1", "ready after reset", req_ready, 1);
      check(mem_ce_n && !mem_dq_oe && !rsp_valid, "R1", "idle after reset",
            {mem_ce_n, mem_dq_oe, rsp_valid}, 4);

      // back-to-back stores at both address extremes
      send(1, 0, 8'h5A);
      send(1, (1 << AW) - 1, 8'hFF);
      send(1, 12'h155, 8'h00);
      // back-to-back loads, including an unwritten location
      send(0, 0, 0);
      send(0, (1 << AW) - 1, 0);
      send(0, 12'h155, 0);
      send(0, 12'h3C3, 0);
      req_valid = 1'b0;
      repeat (20) @(negedge clk);
      // interleaved traffic with idle gaps
      for (int i = 0; i < 6; i++) begin
         send(1, i * 37 + 5, i * 29 + 3);
         send(0, i * 37 + 5, 0);
         req_valid = 1'b0;
         repeat (i * 3) @(negedge clk);
      end
      send(0, 1, 0);
      req_valid = 1'b0;
      repeat (80) @(negedge clk);
      check(txq.size() == 0, "R2", "all requests executed", txq.size(), 0);
      check(txns == 20, "R2", "one enable phase per request", txns, 20);
      done = 1;
      summary();
      $finish;
   end

endmodule